// File: doc/BRIEF.md
# Phase-Interleaved Memory Write Sequencer

This block writes single bits into a small 1-bit-wide memory whose address lines are also used by a display scanner. A free-running ring of ten one-hot phase strobes divides time. The scanner uses some of these phases. The sequencer places its whole write inside the phases the scanner leaves alone, so the displayed picture never shows a wrong bit while a write is in progress.

A one-cycle command pulse comes with a 7-bit address and a data bit. If no write is under way, the pulse is accepted and the address and data are captured. A chain of four flags then moves ownership of the address bus in steps. First the scanner lets go of the bus. Next the write address takes it. Then write-enable is pulsed for one phase. The steps are then undone in the reverse order. Between the two owners there is always one cycle in which nobody drives the bus. During that cycle the address reads as all ones, which is what pull-up resistors would give. The data-in line is separate from the memory's output, so no bidirectional data bus is needed.

Top module: `phase_write_sequencer`

## Requirements
- R1: Synchronous active-high reset clears every flag. From the cycle after a reset edge, `mem_addr_o` follows `scan_addr_i`, `mem_we_o` is 0 and `bus_float_o` is 0. A reset in the middle of a write cancels that write.
- R2: After a command is accepted, the write starts at the first clock edge sampled with phase 3 (`phase_i[3]`=1) that comes strictly after the accepting edge. This means a write always starts within one ring of ten phases.
- R3: In the cycle after that phase-3 edge, the bus is undriven. `bus_float_o`=1 and `mem_addr_o`=7'h7F.
- R4: After the phase-4, phase-5 and phase-6 edges of a write, `mem_addr_o` equals the captured command address and `bus_float_o`=0.
- R5: `mem_we_o` is 1 for exactly one cycle per write, the cycle after the phase-5 edge. In that cycle `mem_din_o` equals the captured data bit.
- R6: After the phase-7 edge, the bus is again undriven (`bus_float_o`=1, `mem_addr_o`=7'h7F). After the phase-8 edge, the scan address is back on the bus.
- R7: A command pulse is ignored while a write is pending or running. This covers the span from the accepting edge up to and including the phase-8 edge that ends the write. An ignored pulse causes no extra write and does not change the address or data used.
- R8: The address and data are captured on the accepting edge. Changes on `cmd_addr_i` and `cmd_data_i` after that edge do not affect the write.
- R9: With no accepted command, `mem_we_o` stays 0, `bus_float_o` stays 0, and `mem_addr_o` follows `scan_addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 10 | One-hot phase ring, bit k high during phase k |
| cmd_i | input | 1 | One-cycle write command pulse |
| cmd_addr_i | input | 7 | Address that goes with the command |
| cmd_data_i | input | 1 | Data bit that goes with the command |
| scan_addr_i | input | 7 | Address from the display scanner |
| mem_addr_o | output | 7 | Address to the memory |
| mem_din_o | output | 1 | Data-in to the memory |
| mem_we_o | output | 1 | Write-enable to the memory, active high |
| bus_float_o | output | 1 | High when neither source drives the address |

## Verification
The bench aims commands at every phase of the ring, with most weight on phases 3 and 8. At phase 3, a design that claims the bus on the accepting edge would start the write one ring too early. At phase 8, a design that frees itself one edge too soon would accept a second write on top of the first. Commands sent during a running write check that they are dropped. Without this, a design would write twice or would switch to the newer address partway through the write. The command address and data are also changed every cycle after capture, to catch a design that passes them straight through instead of holding them. Writes to address 7'h7F are included, because that value looks the same as the undriven bus. This exposes a design that merges the two ownership handovers into one. Resets in the middle of a write check that write-enable and write-address ownership drop at once.

// File: rtl/pws_pkg.sv
package pws_pkg;

    // positions in the phase ring that the sequencer reacts to
    localparam int PH_CLAIM    = 3;  // scanner lets go of the bus
    localparam int PH_DRIVE    = 4;  // write address takes the bus
    localparam int PH_STROBE   = 5;  // write-enable rises
    localparam int PH_UNSTROBE = 6;  // write-enable falls
    localparam int PH_UNDRIVE  = 7;  // write address lets go
    localparam int PH_RELEASE  = 8;  // scanner gets the bus back
    localparam int PH_MIN      = PH_RELEASE + 1;

    typedef struct packed {
        logic pend;    // request seen, waiting for or inside a write
        logic claim;   // scanner driver disabled
        logic drive;   // second half of the write-driver enable
        logic strobe;  // memory write-enable
    } seq_flags_t;

    typedef enum logic [1:0] {
        OWN_SCAN  = 2'd0,
        OWN_NONE  = 2'd1,
        OWN_WRITE = 2'd2
    } owner_e;

    // write driver enabled only when both claim and drive are set, so an
    // orphan drive flag can never put two sources on the bus
    function automatic owner_e decode_owner(seq_flags_t f);
        if (!f.claim)
            return OWN_SCAN;
        else if (f.drive)
            return OWN_WRITE;
        else
            return OWN_NONE;
    endfunction

    function automatic logic seq_busy(seq_flags_t f);
        return f.pend | f.claim;
    endfunction

endpackage

// File: rtl/pws_flag_chain.sv
module pws_flag_chain
    import pws_pkg::*;
#(
    parameter int NUM_PHASES = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PHASES-1:0] phase_i,
    input  logic                  accept_i,
    output seq_flags_t            flags_o
);

    seq_flags_t flags_q;
    seq_flags_t flags_d;

    generate
        if (NUM_PHASES < PH_MIN) begin : g_bad_ring
            initial $error("phase ring shorter than the write sequence");
        end
    endgenerate

    always_comb begin
        flags_d = flags_q;
        if (accept_i)
            flags_d.pend = 1'b1;
        if (phase_i[PH_CLAIM] && flags_q.pend)
            flags_d.claim = 1'b1;
        if (phase_i[PH_DRIVE] && flags_q.claim)
            flags_d.drive = 1'b1;
        if (phase_i[PH_STROBE] && flags_q.drive)
            flags_d.strobe = 1'b1;
        if (phase_i[PH_UNSTROBE])
            flags_d.strobe = 1'b0;
        if (phase_i[PH_UNDRIVE]) begin
            flags_d.drive = 1'b0;
            // only a request already served by this write is retired
            if (flags_q.claim)
                flags_d.pend = 1'b0;
        end
        if (phase_i[PH_RELEASE])
            flags_d.claim = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    // R2: ring is one-hot
    a_r2_phase_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot(phase_i));

    // R2: a pending request claims the bus on phase 3
    a_r2_claim_on_phase3: assert property (@(posedge clk) disable iff (rst)
        (flags_q.pend && phase_i[PH_CLAIM]) |=> flags_q.claim);

    // R4: later flags only ever stand on earlier ones
    a_r4_drive_needs_claim: assert property (@(posedge clk) disable iff (rst)
        flags_q.drive |-> flags_q.claim);

    // R5: write-enable only inside the driven window, rising after phase 5
    a_r5_strobe_needs_drive: assert property (@(posedge clk) disable iff (rst)
        flags_q.strobe |-> flags_q.drive);

    a_r5_strobe_rise_phase5: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.strobe) |-> $past(phase_i[PH_STROBE]));

    a_r5_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
        flags_q.strobe |=> !flags_q.strobe);

    // R6: phase 8 always hands the bus back
    a_r6_release_phase8: assert property (@(posedge clk) disable iff (rst)
        phase_i[PH_RELEASE] |=> !flags_q.claim);

endmodule

// File: rtl/pws_cmd_latch.sv
module pws_cmd_latch #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              data_o
);

    logic [ADDR_W-1:0] addr_q;
    logic              data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= 1'b0;
        end else if (accept_i) begin
            addr_q <= addr_i;
            data_q <= data_i;
        end
    end

    assign addr_o = addr_q;
    assign data_o = data_q;

endmodule

// File: rtl/pws_addr_mux.sv
module pws_addr_mux
    import pws_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  owner_e            owner_i,
    input  logic [ADDR_W-1:0] scan_addr_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              float_o
);

    logic scan_en;
    logic wr_en;

    assign scan_en = (owner_i == OWN_SCAN);
    assign wr_en   = (owner_i == OWN_WRITE);
    assign float_o = !scan_en && !wr_en;

    // each line: driven by its owner, otherwise pulled high
    generate
        for (genvar b = 0; b < ADDR_W; b++) begin : g_line
            always_comb begin
                if (scan_en)
                    addr_o[b] = scan_addr_i[b];
                else if (wr_en)
                    addr_o[b] = wr_addr_i[b];
                else
                    addr_o[b] = 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/phase_write_sequencer.sv
module phase_write_sequencer
    import pws_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int NUM_PHASES = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PHASES-1:0] phase_i,
    input  logic                  cmd_i,
    input  logic [ADDR_W-1:0]     cmd_addr_i,
    input  logic                  cmd_data_i,
    input  logic [ADDR_W-1:0]     scan_addr_i,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic                  mem_din_o,
    output logic                  mem_we_o,
    output logic                  bus_float_o
);

    seq_flags_t        flags;
    owner_e            owner;
    logic              busy;
    logic              accept;
    logic [ADDR_W-1:0] cap_addr;
    logic              cap_data;

    assign busy   = seq_busy(flags);
    assign accept = cmd_i && !busy;
    assign owner  = decode_owner(flags);

    pws_flag_chain #(
        .NUM_PHASES(NUM_PHASES)
    ) u_chain (
        .clk      (clk),
        .rst      (rst),
        .phase_i  (phase_i),
        .accept_i (accept),
        .flags_o  (flags)
    );

    pws_cmd_latch #(
        .ADDR_W(ADDR_W)
    ) u_latch (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .addr_i   (cmd_addr_i),
        .data_i   (cmd_data_i),
        .addr_o   (cap_addr),
        .data_o   (cap_data)
    );

    pws_addr_mux #(
        .ADDR_W(ADDR_W)
    ) u_mux (
        .owner_i     (owner),
        .scan_addr_i (scan_addr_i),
        .wr_addr_i   (cap_addr),
        .addr_o      (mem_addr_o),
        .float_o     (bus_float_o)
    );

    assign mem_we_o  = flags.strobe;
    assign mem_din_o = cap_data;

    // R7 R8: captured command is frozen while a write is pending or running
    a_r8_capture_held: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(cap_addr) && $stable(cap_data)));

    // R5: write-enable is only ever seen with the write address on the bus
    a_r5_we_with_addr: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (!bus_float_o && mem_addr_o == cap_addr));

    // R9: idle sequencer leaves the scan address on the bus
    a_r9_idle_scan: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mem_addr_o == scan_addr_i && !mem_we_o && !bus_float_o));

    // R3 R6: undriven bus reads as all ones
    a_r3_float_ones: assert property (@(posedge clk) disable iff (rst)
        bus_float_o |-> (&mem_addr_o && !mem_we_o));

endmodule

// File: tb/test_phase_write_sequencer.sv
module test_phase_write_sequencer;

    localparam int AW = 7;
    localparam int NP = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] phase;
    logic          cmd = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_data = 1'b0;
    logic [AW-1:0] scan_addr = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_din;
    logic          mem_we;
    logic          bus_float;

    int pidx = 0;
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string ctx = "";

    // bench model of the write timeline
    int            m_st = 0;   // 0 idle, 1 pending, 2 running
    int            m_p = 0;    // phase sampled on the last edge
    logic          m_valid = 1'b0;
    logic          m_rst = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic          m_data = 1'b0;

    assign phase = NP'(1) << pidx;

    phase_write_sequencer #(.ADDR_W(AW), .NUM_PHASES(NP)) i_phase_write_sequencer (
        .clk         (clk),
        .rst         (rst),
        .phase_i     (phase),
        .cmd_i       (cmd),
        .cmd_addr_i  (cmd_addr),
        .cmd_data_i  (cmd_data),
        .scan_addr_i (scan_addr),
        .mem_addr_o  (mem_addr),
        .mem_din_o   (mem_din),
        .mem_we_o    (mem_we),
        .bus_float_o (bus_float)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        #1 pidx = (pidx + 1) % NP;
        cycles++;
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s %s: actual %0h expected %0h", tag, ctx, what, act, exp);
        end
    endtask

    function automatic string tag_of(int st, int p, logic after_rst);
        if (after_rst) return "R1";
        if (st != 2) return "R9";
        case (p)
            3: return "R2 R3";
            4, 6: return "R4";
            5: return "R5";
            default: return "R6";
        endcase
    endfunction

    // check, then advance the model with the inputs the next edge samples
    always @(negedge clk) begin
        logic [AW-1:0] e_addr;
        logic e_we, e_float, acc;
        string t;
        if (m_valid) begin
            e_we = 1'b0;
            e_float = 1'b0;
            e_addr = scan_addr;
            if (!m_rst && m_st == 2) begin
                if (m_p == 3 || m_p == 7) begin
                    e_float = 1'b1;
                    e_addr = '1;
                end else begin
                    e_addr = m_addr;
                    e_we = (m_p == 5);
                end
            end
            t = tag_of(m_st, m_p, m_rst);
            check(t, "mem_addr", int'(mem_addr), int'(e_addr));
            check(t, "mem_we", int'(mem_we), int'(e_we));
            check(t, "bus_float", int'(bus_float), int'(e_float));
            if (e_we) check("R5", "mem_din", int'(mem_din), int'(m_data));
        end
        if (rst) begin
            m_st = 0;
            m_rst = 1'b1;
            m_valid = 1'b1;
        end else if (m_valid) begin
            m_rst = 1'b0;
            acc = cmd && (m_st == 0);
            if (m_st == 2 && pidx == 8) m_st = 0;
            else if (m_st == 1 && pidx == 3) m_st = 2;
            if (acc) begin
                m_st = 1;
                m_addr = cmd_addr;
                m_data = cmd_data;
            end
        end
        m_p = pidx;
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic go_phase(int k);
        do step(); while (pidx != k);
    endtask

    task automatic send(logic [AW-1:0] a, logic d);
        cmd = 1'b1;
        cmd_addr = a;
        cmd_data = d;
        step();
        cmd = 1'b0;
    endtask

    // R8: keep disturbing the command lines while a write is in flight
    task automatic churn(int n);
        for (int i = 0; i < n; i++) begin
            cmd_addr = AW'($urandom);
            cmd_data = 1'($urandom);
            scan_addr = AW'($urandom);
            step();
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) step();
        ctx = "R1";
        rst = 1'b0;
        scan_addr = 7'h15;
        repeat (4) step();

        ctx = "R9";
        for (int i = 0; i < 30; i++) begin
            scan_addr = AW'($urandom);
            step();
        end

        // accepted on phase 3 itself: waits a full ring
        ctx = "R2";
        go_phase(3);
        send(7'h2A, 1'b1);
        churn(25);

        // just before phase 3: starts at once
        go_phase(2);
        send(7'h11, 1'b0);
        churn(14);

        // all-ones address against the floating bus
        ctx = "R3";
        go_phase(9);
        send(7'h7F, 1'b1);
        churn(14);

        // second command mid-write and at phase 8 are dropped
        ctx = "R7";
        go_phase(1);
        send(7'h05, 1'b1);
        go_phase(5);
        send(7'h6A, 1'b0);
        go_phase(8);
        send(7'h33, 1'b0);
        churn(3);
        // right after release it is taken again
        go_phase(9);
        send(7'h44, 1'b1);
        churn(20);

        ctx = "R8";
        go_phase(0);
        send(7'h19, 1'b1);
        churn(20);

        // reset in the middle of a write
        ctx = "R1";
        go_phase(2);
        send(7'h0F, 1'b1);
        go_phase(5);
        rst = 1'b1;
        step();
        rst = 1'b0;
        churn(15);

        ctx = "random";
        for (int i = 0; i < 3000; i++) begin
            cmd = ($urandom % 12) == 0;
            cmd_addr = ($urandom % 8 == 0) ? 7'h7F : AW'($urandom);
            cmd_data = 1'($urandom);
            scan_addr = AW'($urandom);
            step();
        end
        cmd = 1'b0;
        repeat (12) step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles >= 100000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule